// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small chipset configuration unit. Software reaches it through two byte-wide I/O ports: one selects a register number (the index), the other reads or writes the selected register (the data port). Only five register numbers are backed by storage; every other index is a hole that ignores writes and reads as all ones.

Three of the five registers hold the chip-select window settings. They are exported raw to a separate address decoder, together with a one-cycle pulse that tells the decoder to take up new values. One bit of the window control register also drives a memory-bank select output. A second control bit in that register makes reads of one status register return its OR with an auxiliary register. The block decides which accesses are accepted, what value a read returns and what the registers hold after reset. It does not decide what the power-management registers mean or how the windows are decoded.

Top module: `cfg_index_port`

## Requirements
- R1: A write at the index port address (default 0x0022) loads `io_wdata` into the index register on that clock edge. A read at the index port returns 0xFF.
- R2: The index register keeps its value across data-port reads and writes, so repeated data accesses reach the same register.
- R3: A write at the data port address (default 0x0024) updates the register named by the current index on that clock edge, when that index is one of 0xEA, 0xF7, 0xF8, 0xF9 or 0xFA.
- R4: A data-port write with any other index changes no register.
- R5: `io_rdata` is 0xFF while `io_rd` is low, for a read at any address other than the two ports, and for a data-port read whose index is not implemented.
- R6: A data-port read of index 0xFA returns register 0xFA OR register 0xEA when bit 6 of register 0xF9 is 1. When that bit is 0, it returns register 0xFA alone.
- R7: `bank_sel` equals bit 5 of register 0xF9: 1 selects the upper bank, 0 the lower.
- R8: While `rst_n` is low, and after it is released, every register holds 0x00 except 0xFA, which holds 0x07. The index is 0x00 and `bank_sel` is 0.
- R9: `win_hi`, `win_lo` and `win_ctl` show registers 0xF7, 0xF8 and 0xF9. `win_update` is high for exactly one cycle, starting at the edge that wrote one of those three registers, and is low after any other write.
- R10: Read data is combinational: it is valid in the same cycle that `io_rd` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| bank_sel | output | 1 | Memory-bank select |
| win_hi | output | 8 | Window base, high byte (register 0xF7) |
| win_lo | output | 8 | Window base, low byte (register 0xF8) |
| win_ctl | output | 8 | Window control byte (register 0xF9) |
| win_update | output | 1 | One-cycle pulse after a window register write |

## Verification
Read data has no latency. The bench samples `io_rdata` one time unit after raising `io_rd`, inside the same low clock phase, and no edge is allowed to pass first. Register, index, `bank_sel` and window-byte results are due at the rising edge that samples `io_wr`. They are checked just after that edge. `win_update` is checked just after that edge for the high level and one edge later for the return to low. Each write is removed at the falling edge, so every write strobe is sampled by exactly one rising edge.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int NSLOT     = 5;
  localparam int SL_AUX    = 0;
  localparam int SL_WHI    = 1;
  localparam int SL_WLO    = 2;
  localparam int SL_WCTL   = 3;
  localparam int SL_STAT   = 4;
  localparam int BIT_BANK  = 5;
  localparam int BIT_MERGE = 6;
  localparam int SLOT_W    = $clog2(NSLOT);

  function automatic logic [7:0] slot_code(input int s);
    case (s)
      SL_AUX:  return 8'hEA;
      SL_WHI:  return 8'hF7;
      SL_WLO:  return 8'hF8;
      SL_WCTL: return 8'hF9;
      default: return 8'hFA;
    endcase
  endfunction

  function automatic logic [7:0] slot_rst(input int s);
    return (s == SL_STAT) ? 8'h07 : 8'h00;
  endfunction

endpackage

// File: rtl/cfg_index_latch.sv
module cfg_index_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] din,
  output logic [7:0] idx
);
  logic [7:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (ld) idx_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= 8'h00;
    else        idx <= idx_d;
  end

  // R2: the index moves only on an index-port write
  a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(idx));

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfgport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic [NSLOT*8-1:0] regs_flat,
  output logic               win_update
);
  logic [NSLOT-1:0] sel;
  logic             upd_d;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [7:0] CODE = slot_code(g);
    localparam logic [7:0] RVAL = slot_rst(g);
    logic [7:0] q, d;

    assign sel[g] = (idx == CODE);

    always_comb begin
      d = q;
      if (wr_en && sel[g]) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RVAL;
      else        q <= d;
    end

    assign regs_flat[g*8 +: 8] = q;

    // R3: an accepted write lands in the selected register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == CODE) |=> (q == $past(wdata)));
  end

  always_comb
    upd_d = wr_en && (sel[SL_WHI] || sel[SL_WLO] || sel[SL_WCTL]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_update <= 1'b0;
    else        win_update <= upd_d;
  end

  // R4: writes to unimplemented indices change nothing
  a_r4_hole_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == '0) |=> $stable(regs_flat));

  // R9: the update pulse is never longer than one cycle without a new write
  a_r9_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    (win_update && !upd_d) |=> !win_update);

endmodule

// File: rtl/cfg_read_merge.sv
module cfg_read_merge
  import cfgport_pkg::*;
(
  input  logic               rd_en,
  input  logic [7:0]         idx,
  input  logic [NSLOT*8-1:0] regs_flat,
  output logic [7:0]         rdata
);
  logic [7:0] pick;
  logic       hit;

  always_comb begin
    pick = 8'hFF;
    hit  = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (idx == slot_code(s)) begin
        pick = regs_flat[s*8 +: 8];
        hit  = 1'b1;
      end
    end
    if (idx == slot_code(SL_STAT) && regs_flat[SL_WCTL*8 + BIT_MERGE])
      pick = pick | regs_flat[SL_AUX*8 +: 8];
    rdata = (rd_en && hit) ? pick : 8'hFF;
  end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgport_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              bank_sel,
  output logic [7:0]        win_hi,
  output logic [7:0]        win_lo,
  output logic [7:0]        win_ctl,
  output logic              win_update
);
  logic               idx_ld;
  logic               dat_wr;
  logic               dat_rd;
  logic [7:0]         idx;
  logic [NSLOT*8-1:0] regs_flat;

  assign idx_ld = io_wr && (io_addr == IDX_PORT);
  assign dat_wr = io_wr && (io_addr == DATA_PORT);
  assign dat_rd = io_rd && (io_addr == DATA_PORT);

  cfg_index_latch u_idx (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (idx_ld),
    .din  (io_wdata),
    .idx  (idx)
  );

  cfg_reg_file u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dat_wr),
    .idx       (idx),
    .wdata     (io_wdata),
    .regs_flat (regs_flat),
    .win_update(win_update)
  );

  cfg_read_merge u_rd (
    .rd_en    (dat_rd),
    .idx      (idx),
    .regs_flat(regs_flat),
    .rdata    (io_rdata)
  );

  assign win_hi   = regs_flat[SL_WHI*8 +: 8];
  assign win_lo   = regs_flat[SL_WLO*8 +: 8];
  assign win_ctl  = regs_flat[SL_WCTL*8 +: 8];
  assign bank_sel = win_ctl[BIT_BANK];

  // R7: the bank select follows bit 5 of the last value written to 0xF9
  a_r7_bank_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == 8'hF9) |=> (bank_sel == $past(io_wdata[BIT_BANK])));

  // R1: index-port reads are not decoded
  a_r1_idx_port_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == IDX_PORT) |-> (io_rdata == 8'hFF));

  // R6: merged read covers every bit of the auxiliary register
  a_r6_merge_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && idx == 8'hFA && win_ctl[BIT_MERGE])
      |-> ((io_rdata & regs_flat[SL_AUX*8 +: 8]) == regs_flat[SL_AUX*8 +: 8]));

  // R5: nothing is returned without a read strobe
  a_r5_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'hFF));

endmodule

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;
  localparam logic [15:0] IP = 16'h0022;
  localparam logic [15:0] DP = 16'h0024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        bank_sel;
  logic [7:0]  win_hi, win_lo, win_ctl;
  logic        win_update;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic upd_at_edge;

  always #5 clk = ~clk;

  cfg_index_port u_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bank_sel(bank_sel),
    .win_hi(win_hi), .win_lo(win_lo), .win_ctl(win_ctl), .win_update(win_update)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    upd_at_edge = win_update;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] i, output logic [7:0] d);
    io_write(IP, i);
    io_read(DP, d);
  endtask

  task automatic check_reset_state(input string tag);
    logic [7:0] d;
    chk(bank_sel == 1'b0, "R8 bank", bank_sel, 0);
    chk(win_update == 1'b0, "R8 update", win_update, 0);
    chk({win_hi, win_lo, win_ctl} == 24'h0, "R8 window bytes", {win_hi, win_lo, win_ctl}, 0);
    io_read(DP, d);
    chk(d == 8'hFF, "R8 index zero reads as hole", d, 8'hFF);
    reg_read(8'hEA, d); chk(d == 8'h00, "R8 reg EA", d, 0);
    reg_read(8'hF7, d); chk(d == 8'h00, "R8 reg F7", d, 0);
    reg_read(8'hF8, d); chk(d == 8'h00, "R8 reg F8", d, 0);
    reg_read(8'hF9, d); chk(d == 8'h00, "R8 reg F9", d, 0);
    reg_read(8'hFA, d); chk(d == 8'h07, "R8 reg FA", d, 8'h07);
    $display("reset state checked (%s)", tag);
  endtask

  task automatic t_index_and_repeat();
    logic [7:0] d;
    io_write(IP, 8'hF7);
    io_read(IP, d);
    chk(d == 8'hFF, "R1 index port read", d, 8'hFF);
    io_write(DP, 8'h12);
    chk(win_hi == 8'h12, "R9 win_hi", win_hi, 8'h12);
    chk(upd_at_edge == 1'b1, "R9 pulse high", upd_at_edge, 1);
    @(posedge clk); #1;
    chk(win_update == 1'b0, "R9 pulse ends", win_update, 0);
    io_read(DP, d); chk(d == 8'h12, "R2 R10 first read", d, 8'h12);
    io_read(DP, d); chk(d == 8'h12, "R2 repeat read", d, 8'h12);
    io_write(DP, 8'h13);
    io_read(DP, d); chk(d == 8'h13, "R2 R3 rewrite same index", d, 8'h13);
  endtask

  task automatic t_fill();
    logic [7:0] d;
    io_write(IP, 8'hEA); io_write(DP, 8'h30);
    chk(upd_at_edge == 1'b0, "R9 no pulse for EA", upd_at_edge, 0);
    io_write(IP, 8'hF8); io_write(DP, 8'h34);
    chk(win_lo == 8'h34, "R9 win_lo", win_lo, 8'h34);
    io_write(IP, 8'hF9); io_write(DP, 8'h00);
    io_write(IP, 8'hFA); io_write(DP, 8'h41);
    chk(upd_at_edge == 1'b0, "R9 no pulse for FA", upd_at_edge, 0);
    reg_read(8'hEA, d); chk(d == 8'h30, "R3 EA", d, 8'h30);
    reg_read(8'hF8, d); chk(d == 8'h34, "R3 F8", d, 8'h34);
    reg_read(8'hFA, d); chk(d == 8'h41, "R6 no merge", d, 8'h41);
  endtask

  task automatic t_holes();
    logic [7:0] d;
    foreach (d[k]) begin end
    io_write(IP, 8'h10); io_write(DP, 8'hAA);
    chk(upd_at_edge == 1'b0, "R4 no pulse on hole", upd_at_edge, 0);
    io_read(DP, d); chk(d == 8'hFF, "R5 hole 10", d, 8'hFF);
    io_write(IP, 8'hF6); io_write(DP, 8'hAA);
    io_read(DP, d); chk(d == 8'hFF, "R5 hole F6", d, 8'hFF);
    io_write(IP, 8'hFB); io_write(DP, 8'hAA);
    io_read(DP, d); chk(d == 8'hFF, "R5 hole FB", d, 8'hFF);
    reg_read(8'hEA, d); chk(d == 8'h30, "R4 EA kept", d, 8'h30);
    reg_read(8'hF7, d); chk(d == 8'h13, "R4 F7 kept", d, 8'h13);
    reg_read(8'hF8, d); chk(d == 8'h34, "R4 F8 kept", d, 8'h34);
    reg_read(8'hF9, d); chk(d == 8'h00, "R4 F9 kept", d, 8'h00);
    reg_read(8'hFA, d); chk(d == 8'h41, "R4 FA kept", d, 8'h41);
  endtask

  task automatic t_merge_bank();
    logic [7:0] d;
    io_write(IP, 8'hF9); io_write(DP, 8'h40);
    chk(bank_sel == 1'b0, "R7 bank low", bank_sel, 0);
    reg_read(8'hFA, d); chk(d == 8'h71, "R6 merged read", d, 8'h71);
    io_write(IP, 8'hF9); io_write(DP, 8'h20);
    chk(bank_sel == 1'b1, "R7 bank high", bank_sel, 1);
    chk(win_ctl == 8'h20, "R9 win_ctl", win_ctl, 8'h20);
    reg_read(8'hFA, d); chk(d == 8'h41, "R6 merge off again", d, 8'h41);
    io_write(IP, 8'hF9); io_write(DP, 8'h60);
    reg_read(8'hFA, d); chk(d == 8'h71, "R6 merged with bank set", d, 8'h71);
    chk(bank_sel == 1'b1, "R7 bank with merge", bank_sel, 1);
  endtask

  task automatic t_strobes();
    logic [7:0] d;
    io_write(IP, 8'hEA);
    @(negedge clk);
    io_addr = DP; io_rd = 1'b0;
    #1 chk(io_rdata == 8'hFF, "R5 no strobe", io_rdata, 8'hFF);
    io_read(16'h0023, d); chk(d == 8'hFF, "R5 other address", d, 8'hFF);
    io_read(DP, d); chk(d == 8'h30, "R10 same-cycle read", d, 8'h30);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("power-up");
    t_index_and_repeat();
    t_fill();
    t_holes();
    t_merge_bank();
    t_strobes();
    @(negedge clk); rst_n = 1'b0;
    #1 chk(bank_sel == 1'b0, "R8 bank during reset", bank_sel, 0);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check_reset_state("mid-run");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule